// File: doc/BRIEF.md
# Windowed Threshold Interrupt With Persistence

This block watches a stream of 16-bit measurement results and decides when they have left a programmable window for long enough to raise an alarm. Each result arrives with a one-cycle valid pulse. The block compares it against an upper bound and a lower bound. Each bound is programmed as a single byte that forms the upper half of a 16-bit value, and the lower half of that value is always zero.

Results that fall outside the window are counted as a run of consecutive events. Any result inside the window resets the run. When the run reaches the persistence count selected by a 2-bit field, a sticky flag is set. The flag drives an active-low interrupt output and stays set until software clears it. Software clears it either by writing 0 to the flag bit or by pulsing a dedicated clear strobe. If a new trigger arrives in the same cycle as a clear, the flag stays set.

Top module: `wthr_irq`

## Requirements
- R1: The upper bound is `{hi_byte, 8'h00}` and the lower bound is `{lo_byte, 8'h00}`. Each byte is loaded from `thr_wdata` on a cycle where `thr_we_hi` or `thr_we_lo` is high, and takes effect for results sampled on the following cycles.
- R2: After reset the upper byte is 0xFF, the lower byte is 0x00, `flag` is 0 and `irq_n` is 1.
- R3: A valid result is out of window when it is strictly greater than the upper bound or strictly less than the lower bound. A result equal to either bound is in window.
- R4: `persist_sel` sets the run length needed to trigger: 0 needs 1 result, 1 needs 4, 2 needs 8 and 3 needs 16 consecutive out-of-window results. The flag is visible in the cycle after the valid pulse of the triggering result.
- R5: A valid in-window result resets the run of consecutive out-of-window results to zero.
- R6: Once set, `flag` stays set through any later results, in window or not, until a clear.
- R7: A cycle with `flag_we` high and `flag_wval` 0 clears the flag. With `flag_wval` 1 the write has no effect.
- R8: A one-cycle pulse on `clr_int` clears the flag.
- R9: When a trigger and a clear happen in the same cycle, the flag is set afterwards.
- R10: `irq_n` is low exactly while `flag` is high.
- R11: The run count saturates at 16 and never wraps. After 16 or more consecutive out-of-window results and a clear, the next out-of-window result triggers again even with a persistence of 16.
- R12: Cycles with `res_valid` low neither advance nor reset the run, whatever `res_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse marking a completed result |
| res_data | input | 16 | Result value |
| thr_we_hi | input | 1 | Load strobe for the upper threshold byte |
| thr_we_lo | input | 1 | Load strobe for the lower threshold byte |
| thr_wdata | input | 8 | Threshold byte to load |
| persist_sel | input | 2 | Persistence selector |
| flag_we | input | 1 | Write strobe for the flag bit |
| flag_wval | input | 1 | Value written to the flag bit (only 0 acts) |
| clr_int | input | 1 | Clear-interrupt strobe |
| flag | output | 1 | Sticky interrupt flag for readback |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
Several properties are checked on every cycle. The run count stays within its saturation bound. An in-window result zeroes the count, and a cycle without a valid result leaves it unchanged. A trigger always leaves the flag set, the flag never sets without a trigger, and it never drops without a clear. The threshold bytes change only on their load strobes. The exact boundary decisions, the mapping from selector code to run length, reset values and the saturation-then-retrigger behaviour are shown only by the bench. The bench sweeps several bound pairs, every selector code and mixed clear and trigger sequences against an arithmetic model.

// File: rtl/wthr_pkg.sv
package wthr_pkg;
    localparam int RES_W   = 16;
    localparam int THR_W   = 8;
    localparam int PSEL_W  = 2;
    // longest run: 1 << (2**PSEL_W)
    localparam int CNT_MAX = 1 << (1 << PSEL_W);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    // selector 0 -> 1, k>0 -> 2**(k+1)
    function automatic cnt_t persist_need(input logic [PSEL_W-1:0] sel);
        cnt_t r;
        if (sel == '0) r = cnt_t'(1);
        else           r = cnt_t'(1) << (int'(sel) + 1);
        return r;
    endfunction

    typedef struct packed {
        logic [THR_W-1:0] hi;
        logic [THR_W-1:0] lo;
    } thr_state_t;

    typedef struct packed {
        cnt_t cnt;
    } run_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/wthr_regs.sv
module wthr_regs
    import wthr_pkg::*;
#(
    parameter int BW = THR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_hi,
    input  logic          we_lo,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] hi_q,
    output logic [BW-1:0] lo_q
);
    logic [BW-1:0] hi_d, lo_d;
    logic [BW-1:0] hi_r, lo_r;

    always_comb begin
        hi_d = hi_r;
        lo_d = lo_r;
        if (we_hi) hi_d = wdata;
        if (we_lo) lo_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_r <= '1;
            lo_r <= '0;
        end else begin
            hi_r <= hi_d;
            lo_r <= lo_d;
        end
    end

    assign hi_q = hi_r;
    assign lo_q = lo_r;

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_hi |=> $stable(hi_q)); // R1
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_lo |=> $stable(lo_q)); // R1
endmodule

// File: rtl/wthr_cmp.sv
module wthr_cmp
    import wthr_pkg::*;
#(
    parameter int DW = RES_W,
    parameter int BW = THR_W
) (
    input  logic [DW-1:0] res,
    input  logic [BW-1:0] hi_byte,
    input  logic [BW-1:0] lo_byte,
    output logic          above,
    output logic          below,
    output logic          outside
);
    localparam int PAD_W = DW - BW;

    logic [DW-1:0] hi_full, lo_full;

    always_comb begin
        hi_full = {hi_byte, {PAD_W{1'b0}}};
        lo_full = {lo_byte, {PAD_W{1'b0}}};
        above   = res > hi_full;
        below   = res < lo_full;
        outside = above | below;
    end
endmodule

// File: rtl/wthr_persist.sv
module wthr_persist
    import wthr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              outside,
    input  logic [PSEL_W-1:0] sel,
    output logic              trig
);
    run_state_t st_d, st_q;
    cnt_t       inc;
    cnt_t       need;

    always_comb begin
        st_d = st_q;
        inc  = (st_q.cnt < cnt_t'(CNT_MAX)) ? st_q.cnt + cnt_t'(1) : st_q.cnt;
        need = persist_need(sel);
        trig = 1'b0;
        if (valid) begin
            if (outside) begin
                st_d.cnt = inc;
                trig     = (inc >= need);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= cnt_t'(CNT_MAX)); // R11
    AST_INWIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !outside) |=> (st_q.cnt == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(st_q.cnt)); // R12
endmodule

// File: rtl/wthr_flag.sv
module wthr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    output logic flag_q
);
    logic flag_d;
    logic flag_r;

    always_comb begin
        flag_d = flag_r;
        if (trig)     flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_r <= 1'b0;
        else        flag_r <= flag_d;
    end

    assign flag_q = flag_r;

    AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> flag_q); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q); // R6
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !trig) |=> !flag_q); // R4
endmodule

// File: rtl/wthr_irq.sv
module wthr_irq
    import wthr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              thr_we_hi,
    input  logic              thr_we_lo,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic [PSEL_W-1:0] persist_sel,
    input  logic              flag_we,
    input  logic              flag_wval,
    input  logic              clr_int,
    output logic              flag,
    output logic              irq_n
);
    logic [THR_W-1:0] hi_q, lo_q;
    logic             above, below, outside;
    logic             trig;
    logic             clr_any;

    wthr_regs #(.BW(THR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (thr_we_hi),
        .we_lo (thr_we_lo),
        .wdata (thr_wdata),
        .hi_q  (hi_q),
        .lo_q  (lo_q)
    );

    wthr_cmp #(.DW(RES_W), .BW(THR_W)) u_cmp (
        .res     (res_data),
        .hi_byte (hi_q),
        .lo_byte (lo_q),
        .above   (above),
        .below   (below),
        .outside (outside)
    );

    wthr_persist u_persist (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (res_valid),
        .outside (outside),
        .sel     (persist_sel),
        .trig    (trig)
    );

    assign clr_any = clr_int | (flag_we & ~flag_wval);

    wthr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .clr    (clr_any),
        .flag_q (flag)
    );

    assign irq_n = ~flag;

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_any && !trig) |=> !flag); // R7 R8
    AST_TRIG_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (res_valid && (above || below))); // R3
endmodule

// File: tb/wthr_irq_tb.sv
module wthr_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        thr_we_hi = 1'b0, thr_we_lo = 1'b0;
    logic [7:0]  thr_wdata = '0;
    logic [1:0]  persist_sel = '0;
    logic        flag_we = 1'b0, flag_wval = 1'b0, clr_int = 1'b0;
    logic        flag, irq_n;

    int checks = 0;
    int errors = 0;

    logic [7:0] hi_m = 8'hFF, lo_m = 8'h00;
    int         cnt_m = 0;
    logic       flag_m = 1'b0;
    int         psel_m = 0;

    always #10 clk = ~clk;

    wthr_irq u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .thr_we_hi(thr_we_hi), .thr_we_lo(thr_we_lo), .thr_wdata(thr_wdata),
        .persist_sel(persist_sel), .flag_we(flag_we), .flag_wval(flag_wval),
        .clr_int(clr_int), .flag(flag), .irq_n(irq_n)
    );

    function automatic int need_of(input int p);
        return (p == 0) ? 1 : (1 << (p + 1));
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d, input logic c,
                        input logic w, input logic wv, input string tag);
        logic outw;
        logic trig;
        @(negedge clk);
        res_valid = v; res_data = d; clr_int = c; flag_we = w; flag_wval = wv;
        @(posedge clk);
        #1;
        res_valid = 1'b0; clr_int = 1'b0; flag_we = 1'b0; flag_wval = 1'b0;
        outw = v && ((d > {hi_m, 8'h00}) || (d < {lo_m, 8'h00}));
        if (v) cnt_m = outw ? ((cnt_m < 16) ? cnt_m + 1 : 16) : 0;
        trig = outw && (cnt_m >= need_of(psel_m));
        if (trig) flag_m = 1'b1;
        else if (c || (w && !wv)) flag_m = 1'b0;
        check(flag, flag_m, tag);
        check(irq_n, ~flag_m, {tag, " R10"});
    endtask

    task automatic set_thr(input logic hi, input logic [7:0] val);
        @(negedge clk);
        thr_we_hi = hi; thr_we_lo = ~hi; thr_wdata = val;
        @(posedge clk);
        #1;
        thr_we_hi = 1'b0; thr_we_lo = 1'b0;
        if (hi) hi_m = val; else lo_m = val;
    endtask

    task automatic set_psel(input int p);
        @(negedge clk);
        persist_sel = 2'(p);
        psel_m = p;
    endtask

    function automatic logic [15:0] mid();
        return 16'(({8'h00, lo_m, 8'h00} + {8'h00, hi_m, 8'h00}) / 2);
    endfunction

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(flag, 1'b0, "R2 reset flag");
        check(irq_n, 1'b1, "R2 reset irq_n");
        @(negedge clk) rst_n = 1'b1;

        // R2 default bounds: 0xFF00 upper, 0x0000 lower
        step(1, 16'h0000, 0, 0, 0, "R2 lower default in window");
        step(1, 16'hFF00, 0, 0, 0, "R2 upper default in window");
        step(1, 16'hFF01, 0, 0, 0, "R2 upper default exceeded");
        step(0, 16'h0000, 1, 0, 0, "R8 clear strobe");

        // R1 R3 boundary sweep
        for (int hsel = 0; hsel < 3; hsel++) begin
            for (int lsel = 0; lsel < 2; lsel++) begin
                logic [7:0] hb, lb;
                hb = (hsel == 0) ? 8'h80 : (hsel == 1) ? 8'h30 : 8'hFE;
                lb = (lsel == 0) ? 8'h20 : 8'h01;
                set_thr(1, hb);
                set_thr(0, lb);
                for (int k = 0; k < 6; k++) begin
                    logic [15:0] val;
                    case (k)
                        0: val = {hb, 8'h00} - 16'd1;
                        1: val = {hb, 8'h00};
                        2: val = {hb, 8'h00} + 16'd1;
                        3: val = {lb, 8'h00} - 16'd1;
                        4: val = {lb, 8'h00};
                        default: val = {lb, 8'h00} + 16'd1;
                    endcase
                    step(1, val, 0, 0, 0, "R1 R3 boundary");
                    step(0, 16'h0000, 1, 0, 0, "R8 clear after boundary");
                end
            end
        end

        // R4 R5 persistence for each selector
        set_thr(1, 8'h80);
        set_thr(0, 8'h20);
        for (int p = 0; p < 4; p++) begin
            set_psel(p);
            step(1, mid(), 1, 0, 0, "R5 reset run");
            for (int i = 0; i < need_of(p) - 1; i++)
                step(1, 16'hF000, 0, 0, 0, "R4 run below need");
            step(1, mid(), 0, 0, 0, "R5 in window breaks run");
            for (int i = 0; i < need_of(p) - 1; i++)
                step(1, 16'h0100, 0, 0, 0, "R4 R5 restarted run");
            check(flag, 1'b0, "R4 not yet triggered");
            step(1, 16'h0100, 0, 0, 0, "R4 run reaches need");
            check(flag, 1'b1, "R4 triggered at need");
            // R6 sticky through in-window results
            for (int i = 0; i < 3; i++) step(1, mid(), 0, 0, 0, "R6 sticky");
            // R12 invalid cycles ignored
            step(0, 16'hFFFF, 0, 0, 0, "R12 idle while set");
            // R7 writes
            step(0, 16'h0000, 0, 1, 1, "R7 write one no effect");
            check(flag, 1'b1, "R7 write one kept flag");
            step(0, 16'h0000, 0, 1, 0, "R7 write zero clears");
            check(flag, 1'b0, "R7 flag cleared");
        end

        // R12 with persistence 1: out-of-window data without valid
        set_psel(0);
        step(1, mid(), 0, 0, 0, "R12 prime");
        for (int i = 0; i < 10; i++) step(0, 16'hFFFF, 0, 0, 0, "R12 no valid");
        check(flag, 1'b0, "R12 flag stayed low");
        // R12: idle cycles do not break a run
        set_psel(1);
        step(1, 16'hF000, 0, 0, 0, "R12 run 1");
        step(1, 16'hF000, 0, 0, 0, "R12 run 2");
        step(0, mid(), 0, 0, 0, "R12 idle in-window data");
        step(1, 16'hF000, 0, 0, 0, "R12 run 3");
        step(1, 16'hF000, 0, 0, 0, "R12 run 4 triggers");
        check(flag, 1'b1, "R12 run survived idle");

        // R9 trigger and clear together
        step(0, 16'h0000, 1, 0, 0, "R8 clear");
        set_psel(0);
        step(1, 16'hF000, 1, 0, 0, "R9 trigger beats strobe");
        check(flag, 1'b1, "R9 strobe");
        step(1, 16'hF000, 0, 1, 0, "R9 trigger beats write zero");
        check(flag, 1'b1, "R9 write");

        // R11 saturation
        set_psel(3);
        step(1, mid(), 1, 0, 0, "R11 reset run");
        for (int i = 0; i < 20; i++) step(1, 16'hF000, 0, 0, 0, "R11 long run");
        step(0, 16'h0000, 1, 0, 0, "R11 clear");
        check(flag, 1'b0, "R11 cleared");
        step(1, 16'hF000, 0, 0, 0, "R11 retrigger");
        check(flag, 1'b1, "R11 saturated count retriggers");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end
endmodule